// File: doc/BRIEF.md
# DMA Transfer Bus-Cycle Sequencer

This block drives the external bus cycles for one DMA channel. Software first loads a control word, a source pointer, a destination pointer and a transfer count through a small register-write port. While the engine is idle and the count is nonzero, an active-high request input starts one transfer. The engine runs that transfer and then returns to idle. It starts the next transfer only if the request is still high.

The engine has two transfer modes. In the two-cycle (dual) mode it first reads from the source pointer and keeps the returned word in an internal buffer. It then writes that word to the destination pointer. In the one-cycle (flyby) mode the active-low acknowledge strobe selects a peripheral while the memory address is on the bus, and the data passes directly between the two devices. A direction bit sets which way the data moves. Each bus cycle is three clocks long: setup, strobe and release. Chip select is low for all three clocks.

After the count runs out, a sticky done flag rises. The flag stays high until the count register is written again.

Top module: `dma_cycle_seq`

## Requirements
- R1: After reset, chip select, read strobe, write strobe and acknowledge are all high (inactive), the data output enable is low and done is low.
- R2: A transfer starts only when the engine is idle, the request is high and the count is nonzero. With a zero count the bus stays inactive. Between two transfers there is at least one clock with chip select high.
- R3: Every bus cycle lasts three clocks with chip select low in all three. The read or write strobe is low only in the middle clock. The two strobes are never low together.
- R4: In dual mode (control bit 0 clear) a transfer is a read cycle at the source pointer followed directly by a write cycle at the destination pointer. During the write cycle the data output is enabled and carries the word that was on the read-data input during the read strobe clock.
- R5: In dual mode, control bit 4 selects where the acknowledge goes. When the bit is set, acknowledge equals chip select in the read cycle and stays high in the write cycle. When the bit is clear, acknowledge stays high in the read cycle and equals chip select in the write cycle.
- R6: In flyby mode (control bit 0 set) a transfer is a single three-clock cycle in which acknowledge equals chip select and the data output is never enabled. With control bit 1 clear, the write strobe fires at the destination pointer. With control bit 1 set, the read strobe fires at the source pointer.
- R7: After each transfer the source pointer advances by XFER_BYTES if control bit 2 is set, and the destination pointer advances by XFER_BYTES if control bit 3 is set. Each pointer wraps modulo 2^ADDR_W. In flyby mode only the pointer that was driven advances.
- R8: Each transfer decrements the count. When the count reaches zero, done is set and stays set until the count register (select 3) is written.
- R9: Register writes (select 0 control, 1 source, 2 destination, 3 count) take effect only while the engine is idle. Writes made during a transfer are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | DATA_W | Register write value |
| dreq | input | 1 | Transfer request, active high |
| bus_rdata | input | DATA_W | Read data from the bus |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Write data to the bus |
| bus_data_oe | output | 1 | Write data output enable |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_dack_n | output | 1 | Peripheral acknowledge, active low |
| done | output | 1 | Sticky count-exhausted flag |

## Verification
The bench applies six channel setups:
- two dual-mode setups, with the acknowledge in the read cycle and in the write cycle;
- two flyby setups, one in each direction;
- a flyby setup with both increments off;
- a source pointer placed just below the top of the address space.

Comparing these setups separates acknowledge placement, strobe choice, address selection and increment or wrap behaviour. During the write cycle the read-data input carries a different word, so the test can tell buffered data from data that passed straight through. Directed tests then cover the reset state, a request made with a zero count, and register writes made while a transfer is running.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_FLY} seq_st_e;
   typedef enum logic [1:0] {PH_SETUP, PH_STROBE, PH_RELEASE} ph_e;
   typedef struct packed {
      logic dack_rd;
      logic dst_inc;
      logic src_inc;
      logic dir;
      logic single;
   } ctrl_t;
   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_SRC  = 2'd1;
   localparam logic [1:0] SEL_DST  = 2'd2;
   localparam logic [1:0] SEL_CNT  = 2'd3;
endpackage

// File: rtl/dma_phase_ctr.sv
module dma_phase_ctr
   import dma_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output ph_e  ph,
   output logic last
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ph <= PH_SETUP;
      else if (!run)
         ph <= PH_SETUP;
      else begin
         case (ph)
            PH_SETUP:  ph <= PH_STROBE;
            PH_STROBE: ph <= PH_RELEASE;
            default:   ph <= PH_SETUP;
         endcase
      end
   end

   assign last = run && (ph == PH_RELEASE);
endmodule

// File: rtl/dma_ptr_reg.sv
module dma_ptr_reg #(
   parameter int W    = 26,
   parameter int STEP = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         bump,
   input  logic         inc_en,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] STEP_W = W'(STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= load_val;
      else if (bump && inc_en)
         q <= q + STEP_W;
   end
endmodule

// File: rtl/dma_cnt_reg.sv
module dma_cnt_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] q,
   output logic         zero,
   output logic         one
);
   localparam logic [W-1:0] ONE_W = W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= load_val;
      else if (dec && (q != '0))
         q <= q - ONE_W;
   end

   assign zero = (q == '0);
   assign one  = (q == ONE_W);
endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W     = 26,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 16,
   parameter int XFER_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              dreq,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_data_oe,
   output logic              bus_cs_n,
   output logic              bus_rd_n,
   output logic              bus_we_n,
   output logic              bus_dack_n,
   output logic              done
);
   localparam int CTRL_W = $bits(ctrl_t);
   localparam int N_PTR  = 2;

   generate
      if (ADDR_W < 2 || ADDR_W > DATA_W) begin : g_bad_addr
         $error("ADDR_W must lie between 2 and DATA_W");
      end
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie between 1 and DATA_W");
      end
      if (DATA_W < CTRL_W) begin : g_bad_data
         $error("DATA_W too narrow for control word");
      end
      if (XFER_BYTES < 1) begin : g_bad_step
         $error("XFER_BYTES must be positive");
      end
   endgenerate

   seq_st_e           st_q;
   ctrl_t             ctrl_q;
   ph_e               ph;
   logic              cyc_last;
   logic              idle;
   logic              cfg_ok;
   logic              start;
   logic              xfer_end;
   logic [CNT_W-1:0]  cnt_q;
   logic              cnt_zero;
   logic              cnt_one;
   logic [DATA_W-1:0] buf_q;
   logic [ADDR_W-1:0] ptr_q [N_PTR];
   logic              use_src;
   logic              strobe;

   assign idle     = (st_q == ST_IDLE);
   assign cfg_ok   = cfg_we && idle;
   assign start    = idle && dreq && !cnt_zero;
   assign xfer_end = cyc_last && ((st_q == ST_WR) || (st_q == ST_FLY));

   dma_phase_ctr u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (!idle),
      .ph    (ph),
      .last  (cyc_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (cfg_ok && cfg_sel == SEL_CTRL)
         ctrl_q <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= ST_IDLE;
      else begin
         case (st_q)
            ST_IDLE: if (start) st_q <= ctrl_q.single ? ST_FLY : ST_RD;
            ST_RD:   if (cyc_last) st_q <= ST_WR;
            default: if (cyc_last) st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         buf_q <= '0;
      else if (st_q == ST_RD && ph == PH_STROBE)
         buf_q <= bus_rdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         done <= 1'b0;
      else if (cfg_ok && cfg_sel == SEL_CNT)
         done <= 1'b0;
      else if (xfer_end && cnt_one)
         done <= 1'b1;
   end

   dma_cnt_reg #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_ok && cfg_sel == SEL_CNT),
      .load_val (cfg_wdata[CNT_W-1:0]),
      .dec      (xfer_end),
      .q        (cnt_q),
      .zero     (cnt_zero),
      .one      (cnt_one)
   );

   generate
      for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
         localparam logic [1:0] MY_SEL = (g == 0) ? SEL_SRC : SEL_DST;
         logic bump_g;
         logic inc_g;
         if (g == 0) begin : g_src
            assign bump_g = xfer_end && (!ctrl_q.single || ctrl_q.dir);
            assign inc_g  = ctrl_q.src_inc;
         end else begin : g_dst
            assign bump_g = xfer_end && (!ctrl_q.single || !ctrl_q.dir);
            assign inc_g  = ctrl_q.dst_inc;
         end
         dma_ptr_reg #(.W(ADDR_W), .STEP(XFER_BYTES)) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (cfg_ok && cfg_sel == MY_SEL),
            .load_val (cfg_wdata[ADDR_W-1:0]),
            .bump     (bump_g),
            .inc_en   (inc_g),
            .q        (ptr_q[g])
         );
      end
   endgenerate

   assign use_src     = (st_q == ST_RD) || (st_q == ST_FLY && ctrl_q.dir);
   assign strobe      = !idle && (ph == PH_STROBE);
   assign bus_cs_n    = idle;
   assign bus_addr    = idle ? '0 : (use_src ? ptr_q[0] : ptr_q[1]);
   assign bus_rd_n    = !(strobe && use_src);
   assign bus_we_n    = !(strobe && !use_src);
   assign bus_dack_n  = !((st_q == ST_FLY) ||
                          (st_q == ST_RD && ctrl_q.dack_rd) ||
                          (st_q == ST_WR && !ctrl_q.dack_rd));
   assign bus_data_oe = (st_q == ST_WR);
   assign bus_wdata   = bus_data_oe ? buf_q : '0;

   // R3
   strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd_n || !bus_we_n) |-> !bus_cs_n);
   // R3
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_n || bus_we_n);
   // R3
   strobe_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_rd_n) || $fell(bus_we_n)) |-> $past(!bus_cs_n));
   // R2
   start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_cs_n) |-> ($past(dreq) && $past(!cnt_zero)));
   // R6
   fly_dack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FLY) |-> (bus_dack_n == bus_cs_n && !bus_data_oe));
   // R5
   rd_dack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RD && ctrl_q.dack_rd) |-> (bus_dack_n == bus_cs_n));
   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (idle && cnt_zero));
endmodule

// File: tb/sim_dma_cycle_seq.sv
`timescale 1ns/1ps
module sim_dma_cycle_seq;
   typedef struct packed {
      logic [4:0]  ctl;
      logic [25:0] src;
      logic [25:0] dst;
      logic [7:0]  cnt;
   } vec_t;

   // ctl bits: 4 dack on read, 3 dst inc, 2 src inc, 1 dir, 0 flyby
   localparam vec_t VECS [6] = '{
      '{5'b11100, 26'h0000100, 26'h0002000, 8'd3},
      '{5'b00100, 26'h3FFFFFC, 26'h0000040, 8'd2},
      '{5'b01001, 26'h0000055, 26'h0000800, 8'd3},
      '{5'b00111, 26'h0001000, 26'h0000009, 8'd2},
      '{5'b00011, 26'h0000077, 26'h0000123, 8'd2},
      '{5'b10000, 26'h0000300, 26'h0000500, 8'd1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [31:0] cfg_wdata = '0;
   logic        dreq = 1'b0;
   logic [31:0] bus_rdata = '0;
   logic [25:0] bus_addr;
   logic [31:0] bus_wdata;
   logic        bus_data_oe, bus_cs_n, bus_rd_n, bus_we_n, bus_dack_n, done;
   int          n_cmp = 0;
   int          n_bad = 0;

   always #5 clk = ~clk;

   dma_cycle_seq u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .dreq(dreq), .bus_rdata(bus_rdata),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_data_oe(bus_data_oe),
      .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n),
      .bus_dack_n(bus_dack_n), .done(done)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg(input logic [1:0] sel, input logic [31:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wait_cs(input string tag);
      for (int k = 0; k < 6 && bus_cs_n; k++) @(negedge clk);
      chk({tag, " start"}, 32'(bus_cs_n), 32'd0);
   endtask

   task automatic chk_cycle(input string tag, input bit wr, input logic [25:0] a,
                            input bit dk, input bit oe, input logic [31:0] wd);
      for (int p = 0; p < 3; p++) begin
         if (p > 0) @(negedge clk);
         chk({"R3 ", tag, " cs_n"}, 32'(bus_cs_n), 32'd0);
         chk({"R7 ", tag, " addr"}, 32'(bus_addr), 32'(a));
         chk({"R3 ", tag, " rd_n"}, 32'(bus_rd_n), 32'(!(p == 1 && !wr)));
         chk({"R3 ", tag, " we_n"}, 32'(bus_we_n), 32'(!(p == 1 && wr)));
         chk({tag, " dack_n"}, 32'(bus_dack_n), 32'(!dk));
         chk({tag, " oe"}, 32'(bus_data_oe), 32'(oe));
         if (oe) chk({"R4 ", tag, " wdata"}, bus_wdata, wd);
      end
   endtask

   task automatic run_vec(input int idx);
      vec_t v;
      logic [25:0] s, d;
      logic [31:0] rv;
      bit fly, dir, drd;
      v = VECS[idx];
      fly = v.ctl[0]; dir = v.ctl[1]; drd = v.ctl[4];
      cfg(2'd0, 32'(v.ctl));
      cfg(2'd1, 32'(v.src));
      cfg(2'd2, 32'(v.dst));
      cfg(2'd3, 32'(v.cnt));
      chk("R8 done cleared by count write", 32'(done), 32'd0);
      s = v.src; d = v.dst;
      dreq = 1'b1;
      for (int t = 0; t < int'(v.cnt); t++) begin
         rv = 32'hC0DE0000 ^ (idx << 12) ^ t;
         if (t > 0) begin
            @(negedge clk);
            chk("R2 idle gap between transfers", 32'(bus_cs_n), 32'd1);
         end
         bus_rdata = rv;
         wait_cs("R2");
         if (fly) begin
            chk_cycle("R6 flyby", !dir, dir ? s : d, 1'b1, 1'b0, 32'd0);
         end else begin
            chk_cycle("R4 R5 dual read", 1'b0, s, drd, 1'b0, 32'd0);
            bus_rdata = ~rv;
            @(negedge clk);
            chk_cycle("R4 R5 dual write", 1'b1, d, !drd, 1'b1, rv);
         end
         if (t == int'(v.cnt) - 1) dreq = 1'b0;
         if ((!fly || dir) && v.ctl[2]) s = s + 26'd4;
         if ((!fly || !dir) && v.ctl[3]) d = d + 26'd4;
      end
      @(negedge clk);
      chk("R8 done after last transfer", 32'(done), 32'd1);
      chk("R8 idle after last transfer", 32'(bus_cs_n), 32'd1);
   endtask

   initial begin
      #2000000;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 cs_n in reset", 32'(bus_cs_n), 32'd1);
      chk("R1 dack_n in reset", 32'(bus_dack_n), 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rd_n after reset", 32'(bus_rd_n), 32'd1);
      chk("R1 we_n after reset", 32'(bus_we_n), 32'd1);
      chk("R1 oe after reset", 32'(bus_data_oe), 32'd0);
      chk("R1 done after reset", 32'(done), 32'd0);

      // R2 zero count blocks requests
      dreq = 1'b1;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk("R2 zero count no cycle", 32'(bus_cs_n), 32'd1);
      end
      dreq = 1'b0;

      for (int i = 0; i < 6; i++) run_vec(i);

      // R8 done sticky, R2 exhausted count ignores request
      dreq = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk("R2 exhausted count no cycle", 32'(bus_cs_n), 32'd1);
         chk("R8 done sticky", 32'(done), 32'd1);
      end
      dreq = 1'b0;

      // R9 writes during a transfer are dropped
      cfg(2'd0, 32'h07);
      cfg(2'd1, 32'h10);
      cfg(2'd3, 32'd2);
      dreq = 1'b1;
      wait_cs("R9 first");
      cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 32'h3333;
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 32'd9;
      @(negedge clk);
      cfg_we = 1'b0;
      for (int k = 0; k < 6 && !bus_cs_n; k++) @(negedge clk);
      wait_cs("R9 second");
      chk("R9 source pointer kept", 32'(bus_addr), 32'h14);
      dreq = 1'b0;
      repeat (4) @(negedge clk);
      chk("R9 count write dropped", 32'(done), 32'd1);
      chk("R9 bus idle", 32'(bus_cs_n), 32'd1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule